// File: doc/BRIEF.md
# SPI Buffer Status Flags

This block keeps track of the transmit and receive buffers of an SPI peripheral and reports their state as one 32-bit status word. The CPU side pushes transmit words and pops receive words. The shifter side pulls transmit words into the shift register, delivers completed receive words and signals transfer activity. The block itself owns the buffer storage, so it also returns read data to the CPU and supplies the head transmit word to the shifter.

There are two buffering modes. In the single-buffer mode each direction has one holding register, and the full and empty flags follow the handshake between the CPU and the shifter. In the queued mode each direction is a small FIFO. The element counts appear in the status word, and the flags are decoded from those counts. Receive overflow and frame error are sticky until software clears them. A transmit underrun either halts the transmit path until it is cleared, or follows the live condition without halting anything, depending on a control input.

Top module: `spi_buf_status`

## Requirements
- R1: After reset the status word reads 0x0000_0028, with receive-empty in bit 5 and transmit-empty in bit 3 set and every other bit clear, and `rd_data` reads 0.
- R2: The status word carries the receive count in bits 26:24 and the transmit count in bits 18:16 while `enh_mode` is 1. Both fields read 0 while `enh_mode` is 0.
- R3: With `enh_mode` = 0, a CPU write sets transmit-full (bit 1) and clears transmit-empty (bit 3). Moving the word into the shifter reverses both flags. A write while the holding register is full is dropped.
- R4: With `enh_mode` = 0, a completed receive word sets receive-full (bit 0) and clears receive-empty (bit 5). A CPU read reverses both flags.
- R5: With `enh_mode` = 1, each empty flag is set exactly when its count is 0, and each full flag exactly when its count is 3. A CPU write and a shifter load in the same cycle leave the transmit count unchanged. A write while the FIFO is full is dropped.
- R6: A CPU read returns the oldest receive word on `rd_data` after the sampling edge. A read while the receive buffer is empty leaves `rd_data` and the count unchanged.
- R7: A receive word that completes while the receive buffer is full is discarded and sets overflow (bit 6). Overflow stays set until `clr_ovf` is pulsed.
- R8: Bit 7 is 1 only while the block is enabled, the transmit buffer is empty, and the shifter holds no loaded word. A loaded word counts as held until the next `sh_rx_done`.
- R9: With `ign_udr` = 0, a load request with an empty transmit buffer sets a sticky underrun flag (bit 8) and raises `tx_stall`. Later load requests are refused until `clr_udr` is pulsed.
- R10: With `ign_udr` = 1, bit 8 shows, for each cycle, whether that cycle's load request met an empty transmit buffer. It never stalls loads.
- R11: While `en` is 0, both buffers are emptied, the shifter-held marker and the underrun flag are cleared, and CPU and shifter strobes have no effect.
- R12: A `frm_err` pulse sets bit 12 until `clr_frm` is pulsed. Bit 11 shows `sh_active` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Peripheral enable |
| enh_mode | input | 1 | 1 selects queued (FIFO) mode, 0 selects single-buffer mode |
| ign_udr | input | 1 | 1 makes underrun a live, non-stalling indication |
| cpu_wr | input | 1 | CPU write strobe into the transmit buffer |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rd | input | 1 | CPU read strobe from the receive buffer |
| sh_load | input | 1 | Shifter request to take the next transmit word |
| sh_rx_done | input | 1 | Shifter finished a word in both directions |
| sh_rx_data | input | DATA_W | Completed receive word |
| sh_active | input | 1 | Transfer in progress |
| frm_err | input | 1 | Frame error event |
| clr_ovf | input | 1 | Clear strobe for overflow |
| clr_udr | input | 1 | Clear strobe for underrun |
| clr_frm | input | 1 | Clear strobe for frame error |
| status | output | 32 | Status word |
| rd_data | output | DATA_W | Last word popped by the CPU |
| sh_tx_data | output | DATA_W | Head of the transmit buffer, for the shifter |
| tx_stall | output | 1 | Transmit path halted by a sticky underrun |

## Verification
Every strobe is sampled on a rising edge, and its result is visible in `status`, `rd_data` and `tx_stall` right after that same edge. Busy is a registered copy of `sh_active`, so it shows the value from one cycle earlier. `sh_tx_data` follows the buffer head combinationally. The bench drives inputs on falling edges and samples one falling edge later, so each result is read exactly one rising edge after its stimulus. Strobes are withdrawn before the next edge, so a pulse never acts twice. The vector table drives a long sequence in queued mode, whose expected status words were worked out by hand from the requirements. Directed tests then cover reset, FIFO order, the clear strobes, the two underrun behaviours, disabling, and single-buffer mode.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int STAT_W = 32;
  localparam int CNT_W  = 3;

  // Bit positions other blocks decode
  localparam int B_RBF  = 0;
  localparam int B_TBF  = 1;
  localparam int B_TBE  = 3;
  localparam int B_RBE  = 5;
  localparam int B_OVF  = 6;
  localparam int B_SRMT = 7;
  localparam int B_UDR  = 8;
  localparam int B_BUSY = 11;
  localparam int B_FRM  = 12;
  localparam int B_TXC  = 16;
  localparam int B_RXC  = 24;

  typedef struct packed {
    logic [CNT_W-1:0] rxc;
    logic [CNT_W-1:0] txc;
    logic             frm;
    logic             busy;
    logic             udr;
    logic             srmt;
    logic             ovf;
    logic             rbe;
    logic             tbe;
    logic             tbf;
    logic             rbf;
  } stat_fields_t;

  function automatic logic [STAT_W-1:0] pack_status(input stat_fields_t f);
    logic [STAT_W-1:0] w;
    w                       = '0;
    w[B_RXC +: CNT_W]       = f.rxc;
    w[B_TXC +: CNT_W]       = f.txc;
    w[B_FRM]                = f.frm;
    w[B_BUSY]               = f.busy;
    w[B_UDR]                = f.udr;
    w[B_SRMT]               = f.srmt;
    w[B_OVF]                = f.ovf;
    w[B_RBE]                = f.rbe;
    w[B_TBE]                = f.tbe;
    w[B_TBF]                = f.tbf;
    w[B_RBF]                = f.rbf;
    return w;
  endfunction

endpackage

// File: rtl/spi_stat_fifo.sv
module spi_stat_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 3,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == cap);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = ptr_inc(wp_q);
      if (pop_ok)  rp_d = ptr_inc(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= wdata;
  end

  // R5: occupancy never passes the storage depth
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5: a push into a full buffer without a pop leaves the count alone
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/spi_stat_err.sv
module spi_stat_err (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ign_udr,
  input  logic ovf_evt,
  input  logic frm_evt,
  input  logic udr_evt,
  input  logic clr_ovf,
  input  logic clr_frm,
  input  logic clr_udr,
  output logic ovf,
  output logic frm,
  output logic udr,
  output logic tx_stall
);

  logic ovf_q, ovf_d, frm_q, frm_d, udr_q, udr_d;

  always_comb begin
    ovf_d = ovf_evt | (ovf_q & ~clr_ovf);
    frm_d = frm_evt | (frm_q & ~clr_frm);
    if (!en)          udr_d = 1'b0;
    else if (ign_udr) udr_d = udr_evt;
    else              udr_d = udr_evt | (udr_q & ~clr_udr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      frm_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      frm_q <= frm_d;
      udr_q <= udr_d;
    end
  end

  assign ovf      = ovf_q;
  assign frm      = frm_q;
  assign udr      = udr_q;
  assign tx_stall = udr_q & ~ign_udr;

  // R7: overflow only drops on a clear strobe
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !clr_ovf |=> ovf_q);

  // R12: frame error only drops on a clear strobe
  a_r12_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q && !clr_frm |=> frm_q);

  // R11: a disabled cycle leaves no underrun behind
  a_r11_udr_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !udr_q);

  // R10: live underrun falls as soon as the condition is gone
  a_r10_udr_live: assert property (@(posedge clk) disable iff (!rst_n)
    ign_udr && !udr_evt |=> !udr_q);

endmodule

// File: rtl/spi_buf_status.sv
module spi_buf_status
  import spi_stat_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              enh_mode,
  input  logic              ign_udr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              sh_load,
  input  logic              sh_rx_done,
  input  logic [DATA_W-1:0] sh_rx_data,
  input  logic              sh_active,
  input  logic              frm_err,
  input  logic              clr_ovf,
  input  logic              clr_udr,
  input  logic              clr_frm,
  output logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] sh_tx_data,
  output logic              tx_stall
);

  localparam logic [CNT_W-1:0] CAP_ENH = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] CAP_STD = CNT_W'(1);

  logic [CNT_W-1:0]  cap, tx_cnt, rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_W-1:0] rx_head;
  logic              load_ok, udr_evt, ovf_evt;
  logic              ovf, frm, udr;
  logic              sr_q, sr_d, busy_q, busy_d;
  logic [DATA_W-1:0] rdd_q, rdd_d;
  logic              rd_ok;
  stat_fields_t      f;

  assign cap     = enh_mode ? CAP_ENH : CAP_STD;
  assign load_ok = en && sh_load && !tx_empty && !tx_stall;
  assign udr_evt = en && sh_load && tx_empty;
  assign ovf_evt = en && sh_rx_done && rx_full;
  assign rd_ok   = en && cpu_rd && !rx_empty;

  spi_stat_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!en),
    .cap   (cap),
    .push  (cpu_wr),
    .pop   (load_ok),
    .wdata (cpu_wdata),
    .rdata (sh_tx_data),
    .count (tx_cnt),
    .empty (tx_empty),
    .full  (tx_full)
  );

  spi_stat_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!en),
    .cap   (cap),
    .push  (sh_rx_done),
    .pop   (cpu_rd),
    .wdata (sh_rx_data),
    .rdata (rx_head),
    .count (rx_cnt),
    .empty (rx_empty),
    .full  (rx_full)
  );

  spi_stat_err u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ign_udr  (ign_udr),
    .ovf_evt  (ovf_evt),
    .frm_evt  (en && frm_err),
    .udr_evt  (udr_evt),
    .clr_ovf  (clr_ovf),
    .clr_frm  (clr_frm),
    .clr_udr  (clr_udr),
    .ovf      (ovf),
    .frm      (frm),
    .udr      (udr),
    .tx_stall (tx_stall)
  );

  always_comb begin
    if (!en)              sr_d = 1'b0;
    else if (load_ok)     sr_d = 1'b1;
    else if (sh_rx_done)  sr_d = 1'b0;
    else                  sr_d = sr_q;
    busy_d = en && sh_active;
    rdd_d  = rd_ok ? rx_head : rdd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= 1'b0;
      busy_q <= 1'b0;
      rdd_q  <= '0;
    end else begin
      sr_q   <= sr_d;
      busy_q <= busy_d;
      rdd_q  <= rdd_d;
    end
  end

  always_comb begin
    f.rxc  = enh_mode ? rx_cnt : '0;
    f.txc  = enh_mode ? tx_cnt : '0;
    f.frm  = frm;
    f.busy = busy_q;
    f.udr  = udr;
    f.srmt = en && tx_empty && !sr_q;
    f.ovf  = ovf;
    f.rbe  = rx_empty;
    f.tbe  = tx_empty;
    f.tbf  = tx_full;
    f.rbf  = rx_full;
  end

  assign status  = pack_status(f);
  assign rd_data = rdd_q;

  // R8: shift-register-empty implies an empty transmit buffer
  a_r8_srmt_tbe: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_SRMT] |-> status[B_TBE]);

  // R9: a halted transmit path keeps its occupancy unless the CPU writes
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en && tx_stall && !cpu_wr |=> tx_cnt == $past(tx_cnt));

  // R6: reading an empty receive buffer keeps the last read word
  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    en && cpu_rd && rx_empty |=> $stable(rd_data));

  // R12: busy mirrors the previous cycle's activity
  a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
    en && sh_active |=> status[B_BUSY]);

  // R2: count fields stay zero in single-buffer mode
  a_r2_std_counts: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> status[B_RXC +: CNT_W] == '0 && status[B_TXC +: CNT_W] == '0);

endmodule

// File: tb/spi_buf_status_test.sv
`timescale 1ns/1ps
module spi_buf_status_test;

  localparam int DW = 32;

  logic          clk, rst_n, en, enh_mode, ign_udr;
  logic          cpu_wr, cpu_rd, sh_load, sh_rx_done, sh_active, frm_err;
  logic          clr_ovf, clr_udr, clr_frm;
  logic [DW-1:0] cpu_wdata, sh_rx_data;
  logic [31:0]   status;
  logic [DW-1:0] rd_data, sh_tx_data;
  logic          tx_stall;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  spi_buf_status #(.DATA_W(DW), .FIFO_DEPTH(3)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .enh_mode(enh_mode), .ign_udr(ign_udr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .sh_load(sh_load), .sh_rx_done(sh_rx_done), .sh_rx_data(sh_rx_data),
    .sh_active(sh_active), .frm_err(frm_err),
    .clr_ovf(clr_ovf), .clr_udr(clr_udr), .clr_frm(clr_frm),
    .status(status), .rd_data(rd_data), .sh_tx_data(sh_tx_data),
    .tx_stall(tx_stall)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Strobe byte: 80 wr, 40 rd, 20 load, 10 rx done, 08 active, 04 frame error
  localparam logic [39:0] VEC [19] = '{
    {8'h80, 32'h0001_0020},  // R5 first write
    {8'h80, 32'h0002_0020},  // R5
    {8'h80, 32'h0003_0022},  // R5 full at three
    {8'h80, 32'h0003_0022},  // R5 write while full dropped
    {8'h20, 32'h0002_0020},  // R8 shifter loaded
    {8'hA0, 32'h0002_0020},  // R5 write and load together
    {8'h10, 32'h0102_0000},  // R2 receive count
    {8'h10, 32'h0202_0000},
    {8'h10, 32'h0302_0001},  // R5 receive full
    {8'h10, 32'h0302_0041},  // R7 overflow
    {8'h40, 32'h0202_0040},  // R7 stays after read
    {8'h08, 32'h0202_0840},  // R12 busy
    {8'h04, 32'h0202_1040},  // R12 frame error
    {8'h20, 32'h0201_1040},
    {8'h20, 32'h0200_1048},  // R5 empty at zero
    {8'h10, 32'h0300_10C9},  // R8 shifter drained
    {8'h20, 32'h0300_11C9},  // R9 sticky underrun
    {8'h80, 32'h0301_1141},
    {8'h20, 32'h0301_1141}   // R9 load refused while halted
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {cpu_wr, cpu_rd, sh_load, sh_rx_done, sh_active, frm_err} = '0;
    {clr_ovf, clr_udr, clr_frm} = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; enh_mode = 1'b0; ign_udr = 1'b0;
    cpu_wdata = '0; sh_rx_data = '0;
    idle();
    repeat (3) tick();
    chk(status, 32'h0000_0028, "R1 reset status");
    chk(rd_data, 32'h0, "R1 reset rd_data");
    rst_n = 1'b1;
    tick();
    chk(status, 32'h0000_0028, "R1 after release");

    en = 1'b1; enh_mode = 1'b1;
    tick();
    chk(status, 32'h0000_00A8, "R8 enabled and idle");

    for (int i = 0; i < 19; i++) begin
      {cpu_wr, cpu_rd, sh_load, sh_rx_done, sh_active, frm_err} = VEC[i][39:34];
      cpu_wdata  = 32'h200 + i;
      sh_rx_data = 32'h100 + i;
      tick();
      chk(status, VEC[i][31:0], $sformatf("R2 table row %0d", i));
      idle();
    end
    chk({31'd0, tx_stall}, 32'd1, "R9 stall raised");

    clr_udr = 1'b1; tick(); idle();
    chk(status, 32'h0301_1041, "R9 clear strobe");
    sh_load = 1'b1; tick(); idle();
    chk(status, 32'h0300_1049, "R9 load after clear");

    cpu_rd = 1'b1; tick(); chk(rd_data, 32'h107, "R6 read order first");
    tick(); chk(rd_data, 32'h108, "R6 read order second");
    tick(); chk(rd_data, 32'h10F, "R7 dropped word skipped");
    tick(); idle();
    chk(rd_data, 32'h10F, "R6 empty read keeps data");
    chk(status, 32'h0000_1068, "R6 empty read status");

    clr_ovf = 1'b1; clr_frm = 1'b1; tick(); idle();
    chk(status, 32'h0000_0028, "R7 R12 clear strobes");

    sh_rx_done = 1'b1; tick(); idle();
    sh_load = 1'b1; tick(); idle();
    chk({31'd0, tx_stall}, 32'd1, "R9 underrun halts");
    en = 1'b0; tick();
    chk(status, 32'h0000_0028, "R11 disable clears");
    cpu_wr = 1'b1; sh_rx_done = 1'b1; tick(); idle();
    chk(status, 32'h0000_0028, "R11 strobes ignored");

    en = 1'b1; ign_udr = 1'b1;
    sh_load = 1'b1; tick(); idle();
    chk(status, 32'h0000_01A8, "R10 live underrun");
    chk({31'd0, tx_stall}, 32'd0, "R10 no stall");
    tick();
    chk(status, 32'h0000_00A8, "R10 underrun drops");
    cpu_wr = 1'b1; cpu_wdata = 32'hCAFE; tick(); idle();
    chk(sh_tx_data, 32'hCAFE, "R10 head word");
    sh_load = 1'b1; tick(); idle();
    chk(status, 32'h0000_0028, "R10 load accepted");

    en = 1'b0; tick();
    en = 1'b1; enh_mode = 1'b0; ign_udr = 1'b0; tick();
    chk(status, 32'h0000_00A8, "R4 single mode idle");
    cpu_wr = 1'b1; cpu_wdata = 32'h55; tick();
    chk(status, 32'h0000_0022, "R3 R2 write sets full");
    cpu_wdata = 32'h66; tick(); idle();
    chk(status, 32'h0000_0022, "R3 second write");
    chk(sh_tx_data, 32'h55, "R3 second write dropped");
    sh_load = 1'b1; tick(); idle();
    chk(status, 32'h0000_0028, "R3 load empties");
    sh_rx_done = 1'b1; sh_rx_data = 32'h77; tick();
    chk(status, 32'h0000_0089, "R4 receive sets full");
    sh_rx_data = 32'h88; tick(); idle();
    chk(status, 32'h0000_00C9, "R7 single mode overflow");
    cpu_rd = 1'b1; tick(); idle();
    chk(status, 32'h0000_00E8, "R4 read empties");
    chk(rd_data, 32'h77, "R4 read data");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule